// File: doc/BRIEF.md
# Supervisor and Machine Control Register Bank

This block holds the machine and supervisor control registers of a processor hart: status, interrupt pending and enable, exception and interrupt delegation, trap vectors, scratch, exception PC, cause, bad address and the two counter-enable registers. It has one access port with a 12-bit address, write data and a write enable. Read data and an illegal-access flag are combinational from the address. Writes are committed at the next rising clock edge.

Each register accepts only its legal fields on a write. The status summary-dirty bit is recomputed whenever status is written. The supervisor status, interrupt-pending and interrupt-enable addresses are filtered windows onto the machine registers: status through a fixed field mask, and the interrupt registers through the interrupt-delegation mask. User reads of the cycle, time and instret counters pass through the counter values supplied at the inputs, but only when the matching user enable bit is set.

Top module: `sm_csr_bank`

## Requirements
- R1: A status (0x300) write updates only SIE[1], MIE[3], SPIE[5], MPIE[7], SPP[8], MPP[12:11], FS[14:13], MPRV[17], PUM[18] and MXR[19]. XS[16:15] is also written, but only when HAS_EXT is 1.
- R2: The status VM field [28:24] is written only when the written mode is legal: 0 (bare) always, 8 at XLEN 32, 9 or 10 at XLEN 64. Otherwise the field keeps its old value.
- R3: The status summary-dirty bit (bit XLEN-1) is set after a status write exactly when FS or XS equals 2'b11.
- R4: Writes to the interrupt-pending register (0x344) change only bits 1 and 5.
- R5: The interrupt-delegation register (0x303) keeps bits 1, 5, 9 and 12. The interrupt-enable register (0x304) keeps those bits plus bits 3 and 7. The exception-delegation register (0x302) keeps bits 15:0.
- R6: The supervisor status (0x100) reads and writes only SIE, SPIE, SPP, FS, XS and PUM of the machine status. Its read sets bit XLEN-1 when FS or XS equals 2'b11.
- R7: The supervisor pending (0x144) and enable (0x104) addresses read the machine register ANDed with the delegation mask. Their writes change only delegated bits.
- R8: Writes to the machine (0x305) and supervisor (0x105) trap vectors clear bits 1:0.
- R9: The user (0x320) and supervisor (0x321) counter enables keep bits 2:0. A read of 0xC00, 0xC01 or 0xC02 returns the cycle, time or instret input when user enable bit 0, 1 or 2 respectively is set. Otherwise it is illegal.
- R10: The IDs at 0xF11, 0xF12 and 0xF13 read zero. 0xF14 reads HART_ID.
- R11: An unimplemented address, or a write to any address with bits 11:10 equal to 2'b11, raises the illegal flag with zero read data, and the write is dropped.
- R12: After reset, the machine trap vector holds MTVEC_RST and every other register reads zero.
- R13: Scratch, EPC, cause and bad-address registers (0x140-0x143, 0x340-0x343) store the full written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write enable, committed on the rising edge |
| cycle_in | input | XLEN | Cycle counter value for gated user reads |
| time_in | input | XLEN | Time counter value for gated user reads |
| instret_in | input | XLEN | Retired-instruction counter value for gated user reads |
| csr_rdata | output | XLEN | Read data for csr_addr |
| csr_illegal | output | 1 | Illegal access for the present address and write enable |

## Verification
The bench builds a main instance at XLEN 32 with HAS_EXT 1, HART_ID 5 and a non-zero trap-vector reset value. This places the summary-dirty bit at 31, makes XS writable and leaves Sv32 as the only legal paged mode. A second instance at the default XLEN 64 with no extension shows that XS stays locked, that the dirty bit moves to 63, and that Sv39 is accepted while Sv32 is refused. Both widths therefore exercise the legal-mode and dirty-bit logic.

// File: rtl/sm_csr_pkg.sv
package sm_csr_pkg;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_SSTATUS, SEL_SIE, SEL_STVEC, SEL_SSCRATCH, SEL_SEPC,
        SEL_SCAUSE, SEL_SBAD, SEL_SIP, SEL_MSTATUS, SEL_MEDELEG, SEL_MIDELEG,
        SEL_MIE, SEL_MTVEC, SEL_UCEN, SEL_SCEN, SEL_MSCRATCH, SEL_MEPC,
        SEL_MCAUSE, SEL_MBAD, SEL_MIP, SEL_CYCLE, SEL_TIME, SEL_INSTRET,
        SEL_VENDOR, SEL_ARCH, SEL_IMPL, SEL_HART
    } csr_sel_e;

    // status field masks (low 32 bits)
    localparam logic [31:0] ST_BASE_MASK = 32'h000E_79AA;
    localparam logic [31:0] ST_XS_MASK   = 32'h0001_8000;
    localparam logic [31:0] ST_VM_MASK   = 32'h1F00_0000;
    localparam logic [31:0] ST_SVIEW     = 32'h0005_E122;

    // interrupt bit masks
    localparam logic [31:0] IRQ_PEND_W   = 32'h0000_0022;
    localparam logic [31:0] IRQ_DELEG_W  = 32'h0000_1222;
    localparam logic [31:0] IRQ_EN_W     = 32'h0000_12AA;
    localparam logic [31:0] EXC_DELEG_W  = 32'h0000_FFFF;

    localparam int VM_LO = 24;
    localparam int FS_LO = 13;
    localparam int XS_LO = 15;

endpackage

// File: rtl/sm_csr_decode.sv
module sm_csr_decode
    import sm_csr_pkg::*;
(
    input  logic [11:0] addr,
    output csr_sel_e    sel
);
    always_comb begin
        unique case (addr)
            12'h100: sel = SEL_SSTATUS;
            12'h104: sel = SEL_SIE;
            12'h105: sel = SEL_STVEC;
            12'h140: sel = SEL_SSCRATCH;
            12'h141: sel = SEL_SEPC;
            12'h142: sel = SEL_SCAUSE;
            12'h143: sel = SEL_SBAD;
            12'h144: sel = SEL_SIP;
            12'h300: sel = SEL_MSTATUS;
            12'h302: sel = SEL_MEDELEG;
            12'h303: sel = SEL_MIDELEG;
            12'h304: sel = SEL_MIE;
            12'h305: sel = SEL_MTVEC;
            12'h320: sel = SEL_UCEN;
            12'h321: sel = SEL_SCEN;
            12'h340: sel = SEL_MSCRATCH;
            12'h341: sel = SEL_MEPC;
            12'h342: sel = SEL_MCAUSE;
            12'h343: sel = SEL_MBAD;
            12'h344: sel = SEL_MIP;
            12'hC00: sel = SEL_CYCLE;
            12'hC01: sel = SEL_TIME;
            12'hC02: sel = SEL_INSTRET;
            12'hF11: sel = SEL_VENDOR;
            12'hF12: sel = SEL_ARCH;
            12'hF13: sel = SEL_IMPL;
            12'hF14: sel = SEL_HART;
            default: sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/sm_csr_status.sv
module sm_csr_status
    import sm_csr_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_EXT = 1'b0
) (
    input  logic [XLEN-1:0] cur,
    input  logic [XLEN-1:0] wval,
    output logic [XLEN-1:0] nxt
);
    localparam logic [XLEN-1:0] BASE_M = XLEN'(ST_BASE_MASK);
    localparam logic [XLEN-1:0] XS_M   = HAS_EXT ? XLEN'(ST_XS_MASK) : '0;
    localparam logic [XLEN-1:0] VM_M   = XLEN'(ST_VM_MASK);

    logic [4:0]      vm_w;
    logic            vm_ok;
    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] merged;

    always_comb begin
        vm_w = wval[VM_LO +: 5];
        if (XLEN == 32) vm_ok = (vm_w == 5'd0) || (vm_w == 5'd8);
        else            vm_ok = (vm_w == 5'd0) || (vm_w == 5'd9) || (vm_w == 5'd10);
        mask   = BASE_M | XS_M | (vm_ok ? VM_M : '0);
        merged = (cur & ~mask) | (wval & mask);
        nxt    = merged;
        nxt[XLEN-1] = (merged[FS_LO +: 2] == 2'b11) || (merged[XS_LO +: 2] == 2'b11);
    end
endmodule

// File: rtl/sm_csr_bank.sv
module sm_csr_bank
    import sm_csr_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter bit          HAS_EXT   = 1'b0,
    parameter logic [63:0] HART_ID   = 64'd0,
    parameter logic [63:0] MTVEC_RST = 64'h0000_0000_0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_we,
    input  logic [XLEN-1:0] cycle_in,
    input  logic [XLEN-1:0] time_in,
    input  logic [XLEN-1:0] instret_in,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal
);
    localparam logic [XLEN-1:0] PEND_W  = XLEN'(IRQ_PEND_W);
    localparam logic [XLEN-1:0] DELEG_W = XLEN'(IRQ_DELEG_W);
    localparam logic [XLEN-1:0] EN_W    = XLEN'(IRQ_EN_W);
    localparam logic [XLEN-1:0] EXC_W   = XLEN'(EXC_DELEG_W);
    localparam logic [XLEN-1:0] SVIEW   = XLEN'(ST_SVIEW);
    localparam logic [XLEN-1:0] CEN_W   = XLEN'(3'b111);

    typedef struct packed {
        logic [XLEN-1:0] mstatus;
        logic [XLEN-1:0] mip;
        logic [XLEN-1:0] mie;
        logic [XLEN-1:0] mideleg;
        logic [XLEN-1:0] medeleg;
        logic [XLEN-1:0] mtvec;
        logic [XLEN-1:0] mscratch;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] mbad;
        logic [XLEN-1:0] stvec;
        logic [XLEN-1:0] sscratch;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] sbad;
        logic [XLEN-1:0] ucen;
        logic [XLEN-1:0] scen;
    } regs_t;

    regs_t           state_q, state_d;
    csr_sel_e        sel;
    logic [XLEN-1:0] stat_wval, stat_nxt;
    logic [XLEN-1:0] rdata_d;
    logic            illegal_d;

    // views exported for the bound checker
    logic [XLEN-1:0] mstatus_w, mip_w, mtvec_w, ucen_w;
    assign mstatus_w = state_q.mstatus;
    assign mip_w     = state_q.mip;
    assign mtvec_w   = state_q.mtvec;
    assign ucen_w    = state_q.ucen;

    sm_csr_decode u_dec (
        .addr (csr_addr),
        .sel  (sel)
    );

    assign stat_wval = (sel == SEL_SSTATUS)
                     ? ((state_q.mstatus & ~SVIEW) | (csr_wdata & SVIEW))
                     : csr_wdata;

    sm_csr_status #(.XLEN(XLEN), .HAS_EXT(HAS_EXT)) u_stat (
        .cur  (state_q.mstatus),
        .wval (stat_wval),
        .nxt  (stat_nxt)
    );

    always_comb begin
        logic gated;
        logic ro;
        logic sdirty;
        logic [XLEN-1:0] merged;

        state_d = state_q;
        rdata_d = '0;
        merged  = '0;
        ro      = (csr_addr[11:10] == 2'b11);
        sdirty  = (state_q.mstatus[FS_LO +: 2] == 2'b11) ||
                  (state_q.mstatus[XS_LO +: 2] == 2'b11);

        unique case (sel)
            SEL_CYCLE:   gated = !state_q.ucen[0];
            SEL_TIME:    gated = !state_q.ucen[1];
            SEL_INSTRET: gated = !state_q.ucen[2];
            default:     gated = 1'b0;
        endcase
        illegal_d = (sel == SEL_NONE) || gated || (csr_we && ro);

        unique case (sel)
            SEL_SSTATUS: begin
                rdata_d = state_q.mstatus & SVIEW;
                rdata_d[XLEN-1] = sdirty;
            end
            SEL_SIE:      rdata_d = state_q.mie & state_q.mideleg;
            SEL_SIP:      rdata_d = state_q.mip & state_q.mideleg;
            SEL_STVEC:    rdata_d = state_q.stvec;
            SEL_SSCRATCH: rdata_d = state_q.sscratch;
            SEL_SEPC:     rdata_d = state_q.sepc;
            SEL_SCAUSE:   rdata_d = state_q.scause;
            SEL_SBAD:     rdata_d = state_q.sbad;
            SEL_MSTATUS:  rdata_d = state_q.mstatus;
            SEL_MEDELEG:  rdata_d = state_q.medeleg;
            SEL_MIDELEG:  rdata_d = state_q.mideleg;
            SEL_MIE:      rdata_d = state_q.mie;
            SEL_MTVEC:    rdata_d = state_q.mtvec;
            SEL_UCEN:     rdata_d = state_q.ucen;
            SEL_SCEN:     rdata_d = state_q.scen;
            SEL_MSCRATCH: rdata_d = state_q.mscratch;
            SEL_MEPC:     rdata_d = state_q.mepc;
            SEL_MCAUSE:   rdata_d = state_q.mcause;
            SEL_MBAD:     rdata_d = state_q.mbad;
            SEL_MIP:      rdata_d = state_q.mip;
            SEL_CYCLE:    rdata_d = cycle_in;
            SEL_TIME:     rdata_d = time_in;
            SEL_INSTRET:  rdata_d = instret_in;
            SEL_HART:     rdata_d = XLEN'(HART_ID);
            default:      rdata_d = '0;
        endcase
        if (illegal_d) rdata_d = '0;

        if (csr_we && !illegal_d) begin
            unique case (sel)
                SEL_SSTATUS, SEL_MSTATUS: state_d.mstatus = stat_nxt;
                SEL_SIE: begin
                    merged = (state_q.mie & ~state_q.mideleg) | (csr_wdata & state_q.mideleg);
                    state_d.mie = merged & EN_W;
                end
                SEL_SIP: begin
                    merged = (state_q.mip & ~state_q.mideleg) | (csr_wdata & state_q.mideleg);
                    state_d.mip = (state_q.mip & ~PEND_W) | (merged & PEND_W);
                end
                SEL_MIP:      state_d.mip = (state_q.mip & ~PEND_W) | (csr_wdata & PEND_W);
                SEL_MIE:      state_d.mie = csr_wdata & EN_W;
                SEL_MIDELEG:  state_d.mideleg = csr_wdata & DELEG_W;
                SEL_MEDELEG:  state_d.medeleg = csr_wdata & EXC_W;
                SEL_STVEC:    state_d.stvec = {csr_wdata[XLEN-1:2], 2'b00};
                SEL_MTVEC:    state_d.mtvec = {csr_wdata[XLEN-1:2], 2'b00};
                SEL_SSCRATCH: state_d.sscratch = csr_wdata;
                SEL_SEPC:     state_d.sepc = csr_wdata;
                SEL_SCAUSE:   state_d.scause = csr_wdata;
                SEL_SBAD:     state_d.sbad = csr_wdata;
                SEL_MSCRATCH: state_d.mscratch = csr_wdata;
                SEL_MEPC:     state_d.mepc = csr_wdata;
                SEL_MCAUSE:   state_d.mcause = csr_wdata;
                SEL_MBAD:     state_d.mbad = csr_wdata;
                SEL_UCEN:     state_d.ucen = csr_wdata & CEN_W;
                SEL_SCEN:     state_d.scen = csr_wdata & CEN_W;
                default:      state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.mtvec <= XLEN'(MTVEC_RST);
        end else begin
            state_q <= state_d;
        end
    end

    assign csr_rdata   = rdata_d;
    assign csr_illegal = illegal_d;

endmodule

// File: rtl/sm_csr_bank_chk.sv
module sm_csr_bank_chk
    import sm_csr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [11:0]     csr_addr,
    input logic [XLEN-1:0] csr_wdata,
    input logic            csr_we,
    input logic [XLEN-1:0] csr_rdata,
    input logic            csr_illegal,
    input logic [XLEN-1:0] mstatus_q,
    input logic [XLEN-1:0] mip_q,
    input logic [XLEN-1:0] mtvec_q,
    input logic [XLEN-1:0] ucen_q
);
    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == '0);

    assert_drop_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_illegal) |=> ($stable(mstatus_q) && $stable(mip_q) &&
                                     $stable(mtvec_q) && $stable(ucen_q)));

    assert_pend_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mip_q & ~XLEN'(IRQ_PEND_W)) == '0);

    assert_dirty_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mstatus_q[XLEN-1] == ((mstatus_q[FS_LO +: 2] == 2'b11) ||
                              (mstatus_q[XS_LO +: 2] == 2'b11)));

    assert_vec_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && !csr_illegal && csr_addr == 12'h305) |=>
            (mtvec_q[1:0] == 2'b00 && mtvec_q[XLEN-1:2] == $past(csr_wdata[XLEN-1:2])));

    assert_cen_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ucen_q[XLEN-1:3] == '0);

    assert_cycle_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 12'hC00 && !ucen_q[0]) |-> csr_illegal);
endmodule

bind sm_csr_bank sm_csr_bank_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .csr_wdata   (csr_wdata),
    .csr_we      (csr_we),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .mstatus_q   (mstatus_w),
    .mip_q       (mip_w),
    .mtvec_q     (mtvec_w),
    .ucen_q      (ucen_w)
);

// File: tb/sm_csr_bank_test.sv
module sm_csr_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        illegal;

    logic [11:0] addr2 = '0;
    logic [63:0] wdata2 = '0;
    logic        we2 = 1'b0;
    logic [63:0] rdata2;
    logic        illegal2;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sm_csr_bank #(.XLEN(32), .HAS_EXT(1'b1), .HART_ID(64'd5),
                  .MTVEC_RST(64'h100)) uut (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr), .csr_wdata(wdata),
        .csr_we(we), .cycle_in(32'h1111_1111), .time_in(32'h2222_2222),
        .instret_in(32'h3333_3333), .csr_rdata(rdata), .csr_illegal(illegal)
    );

    sm_csr_bank uut2 (
        .clk(clk), .rst_n(rst_n), .csr_addr(addr2), .csr_wdata(wdata2),
        .csr_we(we2), .cycle_in('0), .time_in('0), .instret_in('0),
        .csr_rdata(rdata2), .csr_illegal(illegal2)
    );

    // {req, addr, wdata, we, expected rdata, expected illegal}
    localparam int NV = 56;
    localparam logic [81:0] VECS [NV] = '{
        {4'd12, 12'h305, 32'h0,         1'b0, 32'h0000_0100, 1'b0}, // R12
        {4'd12, 12'h300, 32'h0,         1'b0, 32'h0,         1'b0}, // R12
        {4'd1,  12'h300, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R1
        {4'd1,  12'h300, 32'h0,         1'b0, 32'h800F_F9AA, 1'b0}, // R1 R3
        {4'd2,  12'h300, 32'h0800_0000, 1'b1, 32'h800F_F9AA, 1'b0}, // R2
        {4'd2,  12'h300, 32'h0,         1'b0, 32'h0800_0000, 1'b0}, // R2 R3 cleared
        {4'd2,  12'h300, 32'h0900_6000, 1'b1, 32'h0800_0000, 1'b0}, // R2
        {4'd3,  12'h300, 32'h0,         1'b0, 32'h8800_6000, 1'b0}, // R3
        {4'd6,  12'h100, 32'h0,         1'b0, 32'h8000_6000, 1'b0}, // R6
        {4'd6,  12'h100, 32'hFFFF_FFFF, 1'b1, 32'h8000_6000, 1'b0}, // R6
        {4'd6,  12'h100, 32'h0,         1'b0, 32'h8005_E122, 1'b0}, // R6
        {4'd6,  12'h300, 32'h0,         1'b0, 32'h8805_E122, 1'b0}, // R6
        {4'd5,  12'h304, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R5
        {4'd5,  12'h304, 32'h0,         1'b0, 32'h0000_12AA, 1'b0}, // R5
        {4'd5,  12'h303, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R5
        {4'd5,  12'h303, 32'h0,         1'b0, 32'h0000_1222, 1'b0}, // R5
        {4'd7,  12'h104, 32'h0,         1'b0, 32'h0000_1222, 1'b0}, // R7
        {4'd7,  12'h303, 32'h0000_0002, 1'b1, 32'h0000_1222, 1'b0}, // R7 setup
        {4'd7,  12'h104, 32'h0,         1'b1, 32'h0000_0002, 1'b0}, // R7
        {4'd7,  12'h304, 32'h0,         1'b0, 32'h0000_12A8, 1'b0}, // R7
        {4'd7,  12'h104, 32'h0,         1'b0, 32'h0,         1'b0}, // R7
        {4'd4,  12'h344, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R4
        {4'd4,  12'h344, 32'h0,         1'b0, 32'h0000_0022, 1'b0}, // R4
        {4'd7,  12'h144, 32'h0,         1'b0, 32'h0000_0002, 1'b0}, // R7
        {4'd7,  12'h144, 32'h0,         1'b1, 32'h0000_0002, 1'b0}, // R7
        {4'd7,  12'h344, 32'h0,         1'b0, 32'h0000_0020, 1'b0}, // R7
        {4'd5,  12'h302, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R5
        {4'd5,  12'h302, 32'h0,         1'b0, 32'h0000_FFFF, 1'b0}, // R5
        {4'd8,  12'h105, 32'h1234_5677, 1'b1, 32'h0,         1'b0}, // R8
        {4'd8,  12'h105, 32'h0,         1'b0, 32'h1234_5674, 1'b0}, // R8
        {4'd8,  12'h305, 32'hFFFF_FFFF, 1'b1, 32'h0000_0100, 1'b0}, // R8
        {4'd8,  12'h305, 32'h0,         1'b0, 32'hFFFF_FFFC, 1'b0}, // R8
        {4'd13, 12'h340, 32'hDEAD_BEEF, 1'b1, 32'h0,         1'b0}, // R13
        {4'd13, 12'h340, 32'h0,         1'b0, 32'hDEAD_BEEF, 1'b0}, // R13
        {4'd13, 12'h341, 32'h8000_0003, 1'b1, 32'h0,         1'b0}, // R13
        {4'd13, 12'h341, 32'h0,         1'b0, 32'h8000_0003, 1'b0}, // R13
        {4'd13, 12'h142, 32'h8000_0005, 1'b1, 32'h0,         1'b0}, // R13
        {4'd13, 12'h142, 32'h0,         1'b0, 32'h8000_0005, 1'b0}, // R13
        {4'd9,  12'hC00, 32'h0,         1'b0, 32'h0,         1'b1}, // R9 gated
        {4'd9,  12'h320, 32'h0000_00FF, 1'b1, 32'h0,         1'b0}, // R9
        {4'd9,  12'h320, 32'h0,         1'b0, 32'h0000_0007, 1'b0}, // R9
        {4'd9,  12'hC00, 32'h0,         1'b0, 32'h1111_1111, 1'b0}, // R9
        {4'd9,  12'hC01, 32'h0,         1'b0, 32'h2222_2222, 1'b0}, // R9
        {4'd9,  12'h320, 32'h0000_0005, 1'b1, 32'h0000_0007, 1'b0}, // R9
        {4'd9,  12'hC01, 32'h0,         1'b0, 32'h0,         1'b1}, // R9 gated
        {4'd9,  12'hC02, 32'h0,         1'b0, 32'h3333_3333, 1'b0}, // R9
        {4'd9,  12'h321, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b0}, // R9
        {4'd9,  12'h321, 32'h0,         1'b0, 32'h0000_0007, 1'b0}, // R9
        {4'd10, 12'hF11, 32'h0,         1'b0, 32'h0,         1'b0}, // R10
        {4'd10, 12'hF12, 32'h0,         1'b0, 32'h0,         1'b0}, // R10
        {4'd10, 12'hF13, 32'h0,         1'b0, 32'h0,         1'b0}, // R10
        {4'd10, 12'hF14, 32'h0,         1'b0, 32'h0000_0005, 1'b0}, // R10
        {4'd11, 12'h7B0, 32'hFFFF_FFFF, 1'b1, 32'h0,         1'b1}, // R11
        {4'd11, 12'hF14, 32'h0000_0009, 1'b1, 32'h0,         1'b1}, // R11
        {4'd11, 12'hF14, 32'h0,         1'b0, 32'h0000_0005, 1'b0}, // R11
        {4'd11, 12'h340, 32'h0,         1'b0, 32'hDEAD_BEEF, 1'b0}  // R11
    };

    task automatic check(input int req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL R0 watchdog actual=%h expected=%h", 1'b0, 1'b1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            addr  = VECS[i][77:66];
            wdata = VECS[i][65:34];
            we    = VECS[i][33];
            #5;
            check(int'(VECS[i][81:78]), 64'(rdata), 64'(VECS[i][32:1]));
            check(int'(VECS[i][81:78]), 64'(illegal), 64'(VECS[i][0]));
        end
        @(negedge clk);
        we = 1'b0;

        // 64-bit instance without extension: R1 XS locked, R2 Sv39 legal, R3 at bit 63
        addr2 = 12'h300; wdata2 = '1; we2 = 1'b1;
        @(negedge clk);
        we2 = 1'b0; #5;
        check(1, rdata2, 64'h8000_0000_000E_79AA); // R1 R3
        @(negedge clk);
        wdata2 = 64'h0000_0000_0900_0000; we2 = 1'b1;
        @(negedge clk);
        we2 = 1'b0; #5;
        check(2, rdata2, 64'h0000_0000_0900_0000); // R2
        @(negedge clk);
        wdata2 = 64'h0000_0000_0800_0000; we2 = 1'b1;
        @(negedge clk);
        we2 = 1'b0; #5;
        check(2, rdata2, 64'h0000_0000_0900_0000); // R2 Sv32 refused
        addr2 = 12'hF14; #1;
        check(10, rdata2, 64'h0);                   // R10

        // reset mid-run: R12
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        addr = 12'h305; #5;
        check(12, 64'(rdata), 64'h100);
        addr = 12'h340; #1;
        check(12, 64'(rdata), 64'h0);
        addr = 12'h300; #1;
        check(12, 64'(rdata), 64'h0);
        addr = 12'hC00; #1;
        check(12, 64'(illegal), 64'h1);
        addr2 = 12'h300; #1;
        check(12, rdata2, 64'h0);

        done = 1'b1;
        finish_run();
    end
endmodule